// File: doc/BRIEF.md
# Capture-Compare Timer with Carrier Modulation

This block is a 16-bit up-counter. It runs from 0 to a programmable period value, then wraps back to 0. The count advances either on a divided version of the block clock or on a period tick supplied by an external 8-bit carrier timer. Several channels watch the counter. Each channel either drives a pulse-width output or records the counter value when a chosen edge appears on its input pin. Overflow and capture events raise sticky flags, and these flags can be combined into one interrupt request.

In carrier mode the counter advances once per carrier period. The selected channel's pulse-width output is gated by the carrier level to form a modulated infrared burst waveform, with no software work per pulse. Software configures the block through a simple write port and reads results from the count, capture and flag outputs. Period and compare values are double-buffered: a write made while the timer runs takes effect at the next wrap.

Top module: `ircc_timer`

## Requirements
- R1: While running, the count increments by one per step and returns to 0 on the step after it reaches the active period. While stopped (control bit 0 clear), the count is held at 0.
- R2: In normal mode, steps come from a prescaler. Control bits [2:1] select the divide ratio: 00 gives 1, 01 gives 8, 10 gives 32, 11 gives 128. The first step comes one full ratio of cycles after the timer starts.
- R3: A channel in PWM mode (config bit 0 clear) drives its output high while the count is below its active compare value. A compare value of 0 therefore keeps the output low. A channel in capture mode drives its output low.
- R4: A period write (address 1) or a compare write (address 5+2*ch) becomes active at the next wrap while running, and within one cycle while stopped.
- R5: A channel in capture mode latches the count present before the clock edge that samples a qualifying edge on its pin. Config bits [2:1] select the qualifying edge: 00 none, 01 rising, 10 falling, 11 both. Any other edge leaves the latched value unchanged.
- R6: A capture sets that channel's flag, reported as flags bit ch+1. Writing 1 to the same bit at address 2 clears it. A capture in the same cycle as the clear leaves the flag set.
- R7: Every wrap sets the overflow flag, reported as flags bit 0. Writing 1 to bit 0 at address 2 clears it. A wrap in the same cycle as the clear leaves the flag set.
- R8: The irq output is high when the overflow flag is set with control bit 4 set, or when any channel flag is set with that channel's config bit 3 set.
- R9: In carrier mode (control bit 3 set), the count advances only on cycles where carrier_tick is high. The prescaler is ignored.
- R10: In carrier mode, ir_out equals the PWM output of channel IR_CH ANDed with carrier_lvl. Outside carrier mode, ir_out is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (0 control, 1 period, 2 flag clear, 4+2*ch channel config, 5+2*ch channel compare) |
| wr_data | input | 16 | Register write data |
| carrier_tick | input | 1 | One-cycle pulse per carrier timer period |
| carrier_lvl | input | 1 | Carrier timer output level |
| cap_pin | input | 5 | Channel input pins, synchronous to clk |
| pwm_out | output | 5 | Channel PWM outputs |
| ir_out | output | 1 | Modulated carrier output |
| count | output | 16 | Current counter value |
| cap_value | output | 80 | Latched capture values, channel ch at bits [16*ch+15:16*ch] |
| flags | output | 6 | Bit 0 overflow, bit ch+1 channel ch capture |
| irq | output | 1 | Interrupt request |

## Verification
A flag can be set and cleared in the same cycle. A wrap or a capture can land in the same cycle as a write-one-to-clear of its flag. The bench provokes both cases. For the overflow case, it runs with a period of 0 so that every cycle wraps, then issues the clear. For the capture case, it raises a capture pin in the same cycle as the clear write. In both cases the flag must read back as set. A compare or period write made mid-period must also not take effect until the wrap; the bench checks this by sampling the output at counts where the old and new values give different results.

// File: rtl/ircc_pkg.sv
package ircc_pkg;

   localparam int PRE_W = 7;

   // control register bit positions
   localparam int C_RUN  = 0;
   localparam int C_DIVL = 1;
   localparam int C_IR   = 3;
   localparam int C_OVFE = 4;
   localparam int CTRL_W = 5;

   // register addresses
   localparam int A_CTRL   = 0;
   localparam int A_PERIOD = 1;
   localparam int A_FCLR   = 2;
   localparam int A_CHBASE = 4;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;

   typedef struct packed {
      logic      irq_en;
      edge_sel_e edge_sel;
      logic      cap_mode;
   } ch_cfg_t;

   function automatic logic [PRE_W-1:0] div_mask(input logic [1:0] sel);
      case (sel)
         2'b00:   div_mask = PRE_W'(0);
         2'b01:   div_mask = PRE_W'(7);
         2'b10:   div_mask = PRE_W'(31);
         default: div_mask = PRE_W'(127);
      endcase
   endfunction

endpackage

// File: rtl/ircc_prescale.sv
module ircc_prescale
   import ircc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] sel,
   output logic       tick
);
   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] mask;

   assign mask = div_mask(sel);
   assign tick = run && ((pre_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pre_q <= '0;
      else if (!run) pre_q <= '0;
      else          pre_q <= pre_q + 1'b1;
   end
endmodule

// File: rtl/ircc_counter.sv
module ircc_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             step,
   input  logic [CNT_W-1:0] period_shadow,
   output logic [CNT_W-1:0] count,
   output logic             wrap,
   output logic             load
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] per_act;

   assign wrap  = run && step && (cnt_q >= per_act);
   assign load  = !run || wrap;
   assign count = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         per_act <= '1;
      end else if (!run) begin
         cnt_q   <= '0;
         per_act <= period_shadow;
      end else if (step) begin
         if (cnt_q >= per_act) begin
            cnt_q   <= '0;
            per_act <= period_shadow;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ircc_channel.sv
module ircc_channel
   import ircc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  ch_cfg_t          cfg,
   input  logic [CNT_W-1:0] cmp_shadow,
   input  logic [CNT_W-1:0] count,
   input  logic             pin,
   output logic             pwm,
   output logic [CNT_W-1:0] cap_value,
   output logic             cap_event,
   output logic [CNT_W-1:0] cmp_act
);
   logic pin_q;
   logic rise;
   logic fall;

   assign rise      = pin && !pin_q;
   assign fall      = !pin && pin_q;
   assign cap_event = cfg.cap_mode &&
                      ((cfg.edge_sel[0] && rise) || (cfg.edge_sel[1] && fall));
   assign pwm       = !cfg.cap_mode && (count < cmp_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q     <= 1'b0;
         cmp_act   <= '0;
         cap_value <= '0;
      end else begin
         pin_q <= pin;
         if (load)      cmp_act   <= cmp_shadow;
         if (cap_event) cap_value <= count;
      end
   end
endmodule

// File: rtl/ircc_timer.sv
module ircc_timer
   import ircc_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int NCH    = 5,
   parameter int IR_CH  = 0,
   parameter int ADDR_W = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [CNT_W-1:0]     wr_data,
   input  logic                 carrier_tick,
   input  logic                 carrier_lvl,
   input  logic [NCH-1:0]       cap_pin,
   output logic [NCH-1:0]       pwm_out,
   output logic                 ir_out,
   output logic [CNT_W-1:0]     count,
   output logic [NCH*CNT_W-1:0] cap_value,
   output logic [NCH:0]         flags,
   output logic                 irq
);
   localparam int TOP_ADDR = A_CHBASE + 2*NCH;

   if (NCH < 1)                     $error("NCH must be at least 1");
   if (IR_CH < 0 || IR_CH >= NCH)   $error("IR_CH out of range");
   if (CNT_W < NCH + 1 || CNT_W < CTRL_W) $error("CNT_W too narrow");
   if ((1 << ADDR_W) < TOP_ADDR)    $error("ADDR_W too narrow");

   logic [CTRL_W-1:0] ctrl_q;
   logic [CNT_W-1:0]  period_q;
   logic              run, ir_mode, ovf_en;
   logic              pre_tick, step, wrap, load;
   logic              ovf_flag;
   logic [NCH-1:0]    ch_flag, ch_en, cap_evt;
   logic [NCH:0]      clr;
   logic [NCH*CNT_W-1:0] cmp_act_flat;

   assign run     = ctrl_q[C_RUN];
   assign ir_mode = ctrl_q[C_IR];
   assign ovf_en  = ctrl_q[C_OVFE];
   assign step    = ir_mode ? carrier_tick : pre_tick;
   assign clr     = (wr_en && wr_addr == ADDR_W'(A_FCLR)) ? wr_data[NCH:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         period_q <= '1;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(A_CTRL))   ctrl_q   <= wr_data[CTRL_W-1:0];
         if (wr_addr == ADDR_W'(A_PERIOD)) period_q <= wr_data;
      end
   end

   ircc_prescale u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .sel  (ctrl_q[C_DIVL +: 2]),
      .tick (pre_tick)
   );

   ircc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .run          (run),
      .step         (step),
      .period_shadow(period_q),
      .count        (count),
      .wrap         (wrap),
      .load         (load)
   );

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      localparam int A_CFG = A_CHBASE + 2*ch;
      localparam int A_CMP = A_CHBASE + 2*ch + 1;
      ch_cfg_t          cfg_q;
      logic [CNT_W-1:0] cmp_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_q <= '0;
            cmp_q <= '0;
         end else if (wr_en) begin
            if (wr_addr == ADDR_W'(A_CFG)) cfg_q <= ch_cfg_t'(wr_data[3:0]);
            if (wr_addr == ADDR_W'(A_CMP)) cmp_q <= wr_data;
         end
      end

      ircc_channel #(.CNT_W(CNT_W)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (load),
         .cfg       (cfg_q),
         .cmp_shadow(cmp_q),
         .count     (count),
         .pin       (cap_pin[ch]),
         .pwm       (pwm_out[ch]),
         .cap_value (cap_value[ch*CNT_W +: CNT_W]),
         .cap_event (cap_evt[ch]),
         .cmp_act   (cmp_act_flat[ch*CNT_W +: CNT_W])
      );

      assign ch_en[ch] = cfg_q.irq_en;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            ch_flag[ch] <= 1'b0;
         else if (cap_evt[ch])  ch_flag[ch] <= 1'b1;
         else if (clr[ch+1])    ch_flag[ch] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ovf_flag <= 1'b0;
      else if (wrap)   ovf_flag <= 1'b1;
      else if (clr[0]) ovf_flag <= 1'b0;
   end

   assign flags  = {ch_flag, ovf_flag};
   assign irq    = (ovf_flag && ovf_en) || |(ch_flag & ch_en);
   assign ir_out = ir_mode && carrier_lvl && pwm_out[IR_CH];

endmodule

// File: rtl/ircc_timer_chk.sv
module ircc_timer_chk #(
   parameter int CNT_W  = 16,
   parameter int NCH    = 5,
   parameter int ADDR_W = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [CNT_W-1:0]     count,
   input logic [NCH-1:0]       pwm_out,
   input logic [NCH*CNT_W-1:0] cmp_act_flat,
   input logic                 ir_mode,
   input logic                 run,
   input logic                 ir_out,
   input logic                 carrier_lvl,
   input logic                 carrier_tick,
   input logic                 wr_en,
   input logic [ADDR_W-1:0]    wr_addr,
   input logic                 wrap,
   input logic [NCH-1:0]       cap_evt,
   input logic [NCH:0]         flags,
   input logic                 irq
);
   p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (count != '0 && count != $past(count)) |-> count == $past(count) + 1'b1);

   p_pwm_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_act_flat[CNT_W-1:0] == '0) |-> !pwm_out[0]);

   p_ovf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> flags[0]);

   p_cap_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|cap_evt) |=> (|flags[NCH:1]));

   p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|flags));

   p_ir_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && ir_mode && !carrier_tick && !(wr_en && wr_addr == '0)) |=> $stable(count));

   p_ir_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !ir_mode |-> !ir_out);

   p_ir_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !carrier_lvl |-> !ir_out);
endmodule

bind ircc_timer ircc_timer_chk #(.CNT_W(CNT_W), .NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .count       (count),
   .pwm_out     (pwm_out),
   .cmp_act_flat(cmp_act_flat),
   .ir_mode     (ir_mode),
   .run         (run),
   .ir_out      (ir_out),
   .carrier_lvl (carrier_lvl),
   .carrier_tick(carrier_tick),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .wrap        (wrap),
   .cap_evt     (cap_evt),
   .flags       (flags),
   .irq         (irq)
);

// File: tb/tb_ircc_timer.sv
`timescale 1ns/1ps
module tb_ircc_timer;
   localparam int NCH = 5;

   typedef struct packed {
      logic [15:0] per;
      logic [15:0] cmp;
      logic [1:0]  sel;
      logic [15:0] ncyc;
   } vec_t;

   localparam vec_t VEC [6] = '{
      '{16'd5, 16'd3, 2'd0, 16'd30},
      '{16'd4, 16'd0, 2'd0, 16'd20},
      '{16'd3, 16'd9, 2'd0, 16'd20},
      '{16'd2, 16'd1, 2'd1, 16'd60},
      '{16'd1, 16'd1, 2'd2, 16'd140},
      '{16'd1, 16'd1, 2'd3, 16'd600}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic carrier_tick = 1'b0;
   logic carrier_lvl = 1'b0;
   logic [NCH-1:0] cap_pin = '0;
   logic [NCH-1:0] pwm_out;
   logic ir_out;
   logic [15:0] count;
   logic [NCH*16-1:0] cap_value;
   logic [NCH:0] flags;
   logic irq;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   ircc_timer dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .carrier_tick(carrier_tick), .carrier_lvl(carrier_lvl), .cap_pin(cap_pin),
      .pwm_out(pwm_out), .ir_out(ir_out), .count(count), .cap_value(cap_value),
      .flags(flags), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic logic [15:0] capv(input int ch);
      return cap_value[ch*16 +: 16];
   endfunction

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int d, exp_cnt;
      logic [15:0] c0;
      step(3);
      rst_n = 1'b1;
      step(1);
      // reset state
      chk(count == 0, "R1 reset count", count, 0);
      chk(pwm_out == 0, "R3 reset pwm", pwm_out, 0);
      chk(flags == 0, "R7 reset flags", flags, 0);
      chk(irq == 0, "R8 reset irq", irq, 0);
      chk(ir_out == 0, "R10 reset ir_out", ir_out, 0);

      // table of PWM / prescaler vectors
      foreach (VEC[v]) begin
         wr(0, 32'(VEC[v].sel) << 1);
         wr(1, VEC[v].per);
         wr(4, 0);
         wr(5, VEC[v].cmp);
         step(1);
         wr(0, 1 | (32'(VEC[v].sel) << 1));
         d = 1 << ((VEC[v].sel == 0) ? 0 : (VEC[v].sel == 1) ? 3 : (VEC[v].sel == 2) ? 5 : 7);
         for (int n = 0; n < int'(VEC[v].ncyc); n++) begin
            exp_cnt = (n / d) % (int'(VEC[v].per) + 1);
            chk(count == 16'(exp_cnt), "R1 R2 count", count, exp_cnt);
            chk(pwm_out[0] == (exp_cnt < int'(VEC[v].cmp)), "R3 pwm", pwm_out[0],
                (exp_cnt < int'(VEC[v].cmp)));
            chk(ir_out == 0, "R10 ir_out outside carrier mode", ir_out, 0);
            @(negedge clk);
         end
      end

      // R4 double-buffered compare and period
      wr(0, 0);
      chk(count == 0, "R1 stopped count held", count, 0);
      wr(1, 9);
      wr(5, 2);
      step(1);
      wr(0, 1);
      step(5);
      wr(5, 7);
      chk(count == 6, "R4 count", count, 6);
      chk(pwm_out[0] == 0, "R4 old compare kept", pwm_out[0], 0);
      step(4);
      chk(count == 0 && pwm_out[0] == 1, "R4 wrap count/pwm", {count, pwm_out[0]}, 1);
      step(3);
      chk(pwm_out[0] == 1, "R4 new compare at wrap", pwm_out[0], 1);
      wr(1, 4);
      step(5);
      chk(count == 9, "R4 old period kept", count, 9);
      step(5);
      chk(count == 4, "R1 new period", count, 4);
      step(1);
      chk(count == 0, "R1 wrap at new period", count, 0);
      chk(flags[0] == 1, "R7 overflow flag set", flags[0], 1);
      chk(irq == 0, "R8 irq masked", irq, 0);
      wr(0, 32'h11);
      chk(irq == 1, "R8 irq from overflow", irq, 1);
      wr(0, 0);
      wr(2, 1);
      chk(flags[0] == 0, "R7 overflow cleared", flags[0], 0);
      chk(irq == 0, "R8 irq drops", irq, 0);

      // R7 wrap and clear in the same cycle
      wr(1, 0);
      step(1);
      wr(0, 1);
      step(2);
      wr(2, 1);
      chk(flags[0] == 1, "R7 set wins over clear", flags[0], 1);
      wr(0, 0);
      wr(2, 1);

      // capture channel 1
      wr(1, 100);
      wr(6, 32'hB);
      step(1);
      wr(0, 1);
      step(7);
      chk(pwm_out[1] == 0, "R3 capture-mode output low", pwm_out[1], 0);
      c0 = count; cap_pin[1] = 1'b1;
      step(1);
      chk(capv(1) == c0, "R5 rising capture", capv(1), c0);
      chk(flags[2] == 1, "R6 capture flag", flags[2], 1);
      chk(irq == 1, "R8 irq from channel", irq, 1);
      step(3);
      cap_pin[1] = 1'b0;
      step(1);
      chk(capv(1) == c0, "R5 falling ignored in rise mode", capv(1), c0);
      wr(2, 4);
      chk(flags[2] == 0, "R6 flag cleared", flags[2], 0);
      step(2);
      wr_en = 1'b1; wr_addr = 4'd2; wr_data = 16'd4;
      c0 = count; cap_pin[1] = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      chk(flags[2] == 1, "R6 capture wins over clear", flags[2], 1);
      chk(capv(1) == c0, "R5 capture during clear", capv(1), c0);
      wr(6, 32'h7);
      step(2);
      c0 = count; cap_pin[1] = 1'b0;
      step(1);
      chk(capv(1) == c0, "R5 both-edge falling capture", capv(1), c0);
      wr(6, 32'h1);
      wr(2, 4);
      c0 = capv(1);
      cap_pin[1] = 1'b1;
      step(2);
      chk(capv(1) == c0, "R5 edge none ignored", capv(1), c0);
      chk(flags[2] == 0, "R6 no flag when edge none", flags[2], 0);
      wr(6, 32'h5);
      step(2);
      c0 = count; cap_pin[1] = 1'b0;
      step(1);
      chk(capv(1) == c0, "R5 falling capture", capv(1), c0);

      // carrier mode R9 R10
      wr(0, 0);
      wr(1, 7);
      wr(4, 0);
      wr(5, 3);
      step(1);
      wr(0, 32'h9);
      exp_cnt = 0;
      for (int i = 0; i < 64; i++) begin
         chk(count == 16'(exp_cnt), "R9 carrier-step count", count, exp_cnt);
         chk(ir_out == ((exp_cnt < 3) && carrier_lvl), "R10 ir_out gating", ir_out,
             ((exp_cnt < 3) && carrier_lvl));
         carrier_tick = (i % 4 == 3);
         carrier_lvl  = ((i / 2) % 2 == 1);
         if (carrier_tick) exp_cnt = (exp_cnt == 7) ? 0 : exp_cnt + 1;
         @(negedge clk);
      end
      carrier_tick = 1'b0;

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule